// File: doc/BRIEF.md
# Banked Fetch Reorder Align Unit

This unit sits between a four-bank micro-op store and the execution back end. Each bank returns four micro-op slots from one set, so a set line is sixteen slots. Every extended block is stored backwards: its last micro-op comes first. A block can take up one bank or several banks of the set, and a bank mask says which ones. Each of the two fetch requests in a cycle gives a mask and an entry offset. The offset counts micro-ops back from the end of the block, so it tells the unit where program flow enters the block.

The unit works in two registered stages. The first stage puts each block's banks in block order, undoes the reversed storage and cuts the block at its entry point. The second stage packs the micro-ops of both blocks into a sixteen-slot output in program order and removes empty slots. When the two requested blocks need a bank in common, only the first block is delivered in that cycle. A stall flag then tells the fetch logic to send the second block again. The output also carries a valid vector and a micro-op count.

Top module: `xbf_align_top`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `out_vld`, `out_cnt` and `out_stall` are all zero.
- R2: The outputs show the result of the inputs sampled two rising clock edges earlier.
- R3: Storage order works as follows. The banks whose mask bit is set are taken in ascending bank index. Each such bank gets a rank, which is the number of set mask bits below it. Slot s of that bank is storage position rank*4+s, and position p holds the micro-op that lies p places before the block end. Output slot 0 holds the entry micro-op, and each later slot holds the next micro-op in program order. Bank b slot s is read from `bank_uop[(b*4+s)*16 +: 16]`, and its valid bit is `bank_vld[b*4+s]`.
- R4: An entry offset k delivers storage positions min(k, 4*banks-1) down to 0. Positions above the entry point are not delivered.
- R5: A slot whose `bank_vld` bit is 0 is dropped. The micro-ops after it move down, so no gap is left in the output.
- R6: When both requests are valid and their masks do not overlap, all micro-ops of request 0 come before all micro-ops of request 1, whatever bank indices the two blocks use.
- R7: When both requests are valid and their masks share at least one bank, only request 0 is delivered and `out_stall` is 1. Otherwise `out_stall` is 0.
- R8: When only request 1 is valid, it is delivered on its own from slot 0, and `out_stall` is 0.
- R9: `out_cnt` equals the number of set bits in `out_vld`, and the set bits of `out_vld` are contiguous from slot 0.
- R10: A request that is not valid, or that has an all-zero mask, adds no micro-ops. A cycle with no valid request gives `out_cnt` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_uop | input | 256 | Micro-ops of the set, four banks of four 16-bit slots |
| bank_vld | input | 16 | One valid bit per bank slot |
| req0_v | input | 1 | First block request is valid |
| req0_mask | input | 4 | Banks used by the first block |
| req0_off | input | 4 | Entry offset of the first block, counted back from its end |
| req1_v | input | 1 | Second block request is valid |
| req1_mask | input | 4 | Banks used by the second block |
| req1_off | input | 4 | Entry offset of the second block, counted back from its end |
| out_uop | output | 256 | Packed micro-ops in program order, slot 0 first |
| out_vld | output | 16 | Valid bit for each output slot |
| out_cnt | output | 5 | Number of valid output micro-ops |
| out_stall | output | 1 | The second block was held back by a bank conflict |

## Verification
The bench covers these corner cases:
- **Offset larger than the block.** The offset must be clamped to the block's capacity. A unit that does not clamp would lose micro-ops or deliver garbage.
- **Offset of zero.** Exactly one micro-op must come out. An off-by-one error in the cut would show here.
- **Masks with gaps (for example banks 1 and 3).** A design that used bank index instead of rank would put micro-ops in the wrong positions.
- **Second block in lower-numbered banks than the first.** A design that packed by bank order would let the second block overtake the first.
- **Holes in the slot valid bits.** These show whether compaction leaves gaps.
- **Overlapping masks, including identical masks.** The stall flag must be raised and the second block must be dropped, not merged into the output.
- **Valid request with an empty mask.** It must add nothing to the output.

A long random phase then compares every cycle against a behavioural queue model. That model holds the two-cycle delay, so the random phase also checks timing.

// File: rtl/xbf_pkg.sv
package xbf_pkg;

  localparam int XBF_NREQ = 2;

  // number of set bits of m in positions [0, upto)
  function automatic int count_below(input logic [31:0] m, input int upto);
    int n;
    n = 0;
    for (int i = 0; i < 32; i++) begin
      if (i < upto && m[i]) n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/xbf_bank_reorder.sv
module xbf_bank_reorder
  import xbf_pkg::*;
#(
  parameter int NB  = 4,
  parameter int SPB = 4,
  parameter int W   = 16,
  localparam int SLOTS = NB * SPB,
  localparam int OFF_W = $clog2(SLOTS)
) (
  input  logic [SLOTS*W-1:0] bank_uop,
  input  logic [SLOTS-1:0]   bank_vld,
  input  logic [NB-1:0]      mask,
  input  logic [OFF_W-1:0]   offset,
  input  logic               en,
  output logic [SLOTS*W-1:0] seq_uop,
  output logic [SLOTS-1:0]   seq_vld
);

  int rank [NB];
  int cap;
  int kk;

  // bank order: rank of every selected bank within the block
  always_comb begin
    for (int b = 0; b < NB; b++) begin
      rank[b] = count_below(32'(mask), b);
    end
    cap = count_below(32'(mask), NB) * SPB;
    kk  = (int'(offset) < cap) ? int'(offset) : cap - 1;
  end

  // reverse storage order and cut at the entry point
  always_comb begin
    int p;
    int j;
    seq_uop = '0;
    seq_vld = '0;
    for (int b = 0; b < NB; b++) begin
      for (int s = 0; s < SPB; s++) begin
        p = rank[b] * SPB + s;
        j = kk - p;
        if (en && mask[b] && p <= kk) begin
          seq_uop[j*W +: W] = bank_uop[(b*SPB+s)*W +: W];
          seq_vld[j]        = bank_vld[b*SPB+s];
        end
      end
    end
  end

endmodule

// File: rtl/xbf_compact.sv
module xbf_compact #(
  parameter int NB  = 4,
  parameter int SPB = 4,
  parameter int W   = 16,
  localparam int SLOTS = NB * SPB,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic [SLOTS*W-1:0] a_uop,
  input  logic [SLOTS-1:0]   a_vld,
  input  logic [SLOTS*W-1:0] b_uop,
  input  logic [SLOTS-1:0]   b_vld,
  output logic [SLOTS*W-1:0] pk_uop,
  output logic [SLOTS-1:0]   pk_vld,
  output logic [CNT_W-1:0]   pk_cnt
);

  // block a first, block b after it; empty slots squeezed out
  always_comb begin
    int idx;
    logic [W-1:0] cu;
    logic         cv;
    pk_uop = '0;
    pk_vld = '0;
    idx    = 0;
    for (int i = 0; i < 2*SLOTS; i++) begin
      if (i < SLOTS) begin
        cu = a_uop[i*W +: W];
        cv = a_vld[i];
      end else begin
        cu = b_uop[(i-SLOTS)*W +: W];
        cv = b_vld[i-SLOTS];
      end
      if (cv && idx < SLOTS) begin
        pk_uop[idx*W +: W] = cu;
        pk_vld[idx]        = 1'b1;
        idx++;
      end
    end
    pk_cnt = CNT_W'(idx);
  end

endmodule

// File: rtl/xbf_align_top.sv
module xbf_align_top
  import xbf_pkg::*;
#(
  parameter int NB  = 4,
  parameter int SPB = 4,
  parameter int W   = 16,
  localparam int SLOTS = NB * SPB,
  localparam int OFF_W = $clog2(SLOTS),
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SLOTS*W-1:0] bank_uop,
  input  logic [SLOTS-1:0]   bank_vld,
  input  logic               req0_v,
  input  logic [NB-1:0]      req0_mask,
  input  logic [OFF_W-1:0]   req0_off,
  input  logic               req1_v,
  input  logic [NB-1:0]      req1_mask,
  input  logic [OFF_W-1:0]   req1_off,
  output logic [SLOTS*W-1:0] out_uop,
  output logic [SLOTS-1:0]   out_vld,
  output logic [CNT_W-1:0]   out_cnt,
  output logic               out_stall
);

  logic               conflict;
  logic [NB-1:0]      rq_mask [XBF_NREQ];
  logic [OFF_W-1:0]   rq_off  [XBF_NREQ];
  logic               rq_en   [XBF_NREQ];
  logic [SLOTS*W-1:0] ro_uop  [XBF_NREQ];
  logic [SLOTS-1:0]   ro_vld  [XBF_NREQ];

  logic [SLOTS*W-1:0] s1_uop  [XBF_NREQ];
  logic [SLOTS-1:0]   s1_vld  [XBF_NREQ];
  logic               s1_stall;

  logic [SLOTS*W-1:0] pk_uop;
  logic [SLOTS-1:0]   pk_vld;
  logic [CNT_W-1:0]   pk_cnt;

  // bank arbitration: second block yields on any shared bank
  assign conflict   = req0_v & req1_v & (|(req0_mask & req1_mask));
  assign rq_mask[0] = req0_mask;
  assign rq_mask[1] = req1_mask;
  assign rq_off[0]  = req0_off;
  assign rq_off[1]  = req1_off;
  assign rq_en[0]   = req0_v;
  assign rq_en[1]   = req1_v & ~conflict;

  // stage 1: per-block bank reorder and reversal
  for (genvar g = 0; g < XBF_NREQ; g++) begin : g_blk
    xbf_bank_reorder #(.NB(NB), .SPB(SPB), .W(W)) u_reorder (
      .bank_uop (bank_uop),
      .bank_vld (bank_vld),
      .mask     (rq_mask[g]),
      .offset   (rq_off[g]),
      .en       (rq_en[g]),
      .seq_uop  (ro_uop[g]),
      .seq_vld  (ro_vld[g])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        s1_uop[g] <= '0;
        s1_vld[g] <= '0;
      end else begin
        s1_uop[g] <= ro_uop[g];
        s1_vld[g] <= ro_vld[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) s1_stall <= 1'b0;
    else     s1_stall <= conflict;
  end

  // stage 2: compaction of both blocks into the output slots
  xbf_compact #(.NB(NB), .SPB(SPB), .W(W)) u_compact (
    .a_uop  (s1_uop[0]),
    .a_vld  (s1_vld[0]),
    .b_uop  (s1_uop[1]),
    .b_vld  (s1_vld[1]),
    .pk_uop (pk_uop),
    .pk_vld (pk_vld),
    .pk_cnt (pk_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_uop   <= '0;
      out_vld   <= '0;
      out_cnt   <= '0;
      out_stall <= 1'b0;
    end else begin
      out_uop   <= pk_uop;
      out_vld   <= pk_vld;
      out_cnt   <= pk_cnt;
      out_stall <= s1_stall;
    end
  end

endmodule

// File: rtl/xbf_align_chk.sv
module xbf_align_chk #(
  parameter int NB  = 4,
  parameter int SPB = 4,
  localparam int SLOTS = NB * SPB,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             req0_v,
  input logic [NB-1:0]    req0_mask,
  input logic             req1_v,
  input logic [NB-1:0]    req1_mask,
  input logic [SLOTS-1:0] out_vld,
  input logic [CNT_W-1:0] out_cnt,
  input logic             out_stall
);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (out_vld == '0 && out_cnt == '0 && !out_stall)); // R1

  AST_CNT_MATCH: assert property (@(posedge clk) disable iff (rst)
    $countones(out_vld) == int'(out_cnt)); // R9

  AST_PACKED_PREFIX: assert property (@(posedge clk) disable iff (rst)
    (out_vld & (out_vld + 1'b1)) == '0); // R9

  AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    out_stall |-> $past(req0_v && req1_v && (|(req0_mask & req1_mask)), 2)); // R7

  AST_CONFLICT_STALLS: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst, 1) && $past(!rst, 2) &&
     $past(req0_v && req1_v && (|(req0_mask & req1_mask)), 2)) |-> out_stall); // R7

  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $past(!req0_v && !req1_v, 2) |-> (out_cnt == '0)); // R10

endmodule

bind xbf_align_top xbf_align_chk #(.NB(NB), .SPB(SPB)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req0_v    (req0_v),
  .req0_mask (req0_mask),
  .req1_v    (req1_v),
  .req1_mask (req1_mask),
  .out_vld   (out_vld),
  .out_cnt   (out_cnt),
  .out_stall (out_stall)
);

// File: tb/tb_xbf_align_top.sv
`timescale 1ns/1ps
module tb_xbf_align_top;

  localparam int NB = 4;
  localparam int SPB = 4;
  localparam int W = 16;
  localparam int SLOTS = NB * SPB;

  typedef struct packed {
    logic [SLOTS*W-1:0] u;
    logic [SLOTS-1:0]   v;
    logic [4:0]         c;
    logic               s;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [SLOTS*W-1:0] bank_uop = '0;
  logic [SLOTS-1:0]   bank_vld = '0;
  logic req0_v = 1'b0, req1_v = 1'b0;
  logic [3:0] req0_mask = '0, req1_mask = '0, req0_off = '0, req1_off = '0;
  logic [SLOTS*W-1:0] out_uop;
  logic [SLOTS-1:0]   out_vld;
  logic [4:0]         out_cnt;
  logic               out_stall;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  exp_t  exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  xbf_align_top #(.NB(NB), .SPB(SPB), .W(W)) dut (
    .clk(clk), .rst(rst), .bank_uop(bank_uop), .bank_vld(bank_vld),
    .req0_v(req0_v), .req0_mask(req0_mask), .req0_off(req0_off),
    .req1_v(req1_v), .req1_mask(req1_mask), .req1_off(req1_off),
    .out_uop(out_uop), .out_vld(out_vld), .out_cnt(out_cnt), .out_stall(out_stall)
  );

  function automatic exp_t model(input bit v0, input logic [3:0] m0, input logic [3:0] o0,
                                 input bit v1, input logic [3:0] m1, input logic [3:0] o1);
    exp_t e;
    logic [W-1:0] outq[$];
    bit conf;
    e = '0;
    conf = v0 && v1 && ((m0 & m1) != 0);
    for (int r = 0; r < 2; r++) begin
      logic [W-1:0] su[$];
      bit sv[$];
      logic [3:0] m;
      int k;
      bit use_it;
      m = (r == 0) ? m0 : m1;
      k = (r == 0) ? int'(o0) : int'(o1);
      use_it = (r == 0) ? v0 : (v1 && !conf);
      if (use_it) begin
        for (int b = 0; b < NB; b++)
          if (m[b])
            for (int s = 0; s < SPB; s++) begin
              su.push_back(bank_uop[(b*SPB+s)*W +: W]);
              sv.push_back(bank_vld[b*SPB+s]);
            end
        if (su.size() > 0) begin
          if (k > su.size() - 1) k = su.size() - 1;
          for (int p = k; p >= 0; p--)
            if (sv[p]) outq.push_back(su[p]);
        end
      end
    end
    for (int i = 0; i < outq.size(); i++) begin
      e.u[i*W +: W] = outq[i];
      e.v[i] = 1'b1;
    end
    e.c = 5'(outq.size());
    e.s = conf;
    return e;
  endfunction

  task automatic compare_head();
    exp_t e;
    string t;
    bit bad;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    checks++;
    bad = (out_vld !== e.v) || (out_cnt !== e.c) || (out_stall !== e.s);
    for (int i = 0; i < SLOTS; i++)
      if (e.v[i] && out_uop[i*W +: W] !== e.u[i*W +: W]) bad = 1;
    if (bad) begin
      fails++;
      $display("FAIL %s (R2 two-cycle result): actual vld=%h cnt=%0d stall=%0b uop=%h expected vld=%h cnt=%0d stall=%0b uop=%h",
               t, out_vld, out_cnt, out_stall, out_uop, e.v, e.c, e.s, e.u);
    end
  endtask

  task automatic cyc(input string tag, input bit v0, input logic [3:0] m0, input logic [3:0] o0,
                     input bit v1, input logic [3:0] m1, input logic [3:0] o1,
                     input logic [SLOTS-1:0] bv);
    @(negedge clk);
    if (exp_q.size() == 2) compare_head();
    for (int i = 0; i < SLOTS; i++) bank_uop[i*W +: W] = W'($urandom);
    bank_vld = bv;
    req0_v = v0; req0_mask = m0; req0_off = o0;
    req1_v = v1; req1_mask = m1; req1_off = o1;
    exp_q.push_back(model(v0, m0, o0, v1, m1, o1));
    tag_q.push_back(tag);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog: actual run still busy expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_vld !== '0 || out_cnt !== '0 || out_stall !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: actual vld=%h cnt=%0d stall=%0b expected 0 0 0", out_vld, out_cnt, out_stall);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (out_vld !== '0 || out_cnt !== '0 || out_stall !== 1'b0) begin
      fails++;
      $display("FAIL R1 after reset: actual vld=%h cnt=%0d stall=%0b expected 0 0 0", out_vld, out_cnt, out_stall);
    end

    cyc("R3 single bank",       1, 4'b0001, 4'd3,  0, 4'b0000, 4'd0, '1);
    cyc("R3 gapped mask",       1, 4'b1010, 4'd7,  0, 4'b0000, 4'd0, '1);
    cyc("R4 partial entry",     1, 4'b0110, 4'd2,  0, 4'b0000, 4'd0, '1);
    cyc("R4 offset clamp",      1, 4'b0001, 4'd15, 0, 4'b0000, 4'd0, '1);
    cyc("R4 offset zero",       1, 4'b1000, 4'd0,  0, 4'b0000, 4'd0, '1);
    cyc("R5 empty slots",       1, 4'b0011, 4'd7,  0, 4'b0000, 4'd0, 16'h5A3C);
    cyc("R6 two blocks",        1, 4'b0011, 4'd7,  1, 4'b1100, 4'd5, '1);
    cyc("R6 block1 lower bank", 1, 4'b0100, 4'd3,  1, 4'b0001, 4'd1, '1);
    cyc("R6 both with holes",   1, 4'b1001, 4'd6,  1, 4'b0110, 4'd7, 16'hB6D9);
    cyc("R7 partial overlap",   1, 4'b0011, 4'd5,  1, 4'b0110, 4'd6, '1);
    cyc("R7 same banks",        1, 4'b1111, 4'd15, 1, 4'b1111, 4'd9, '1);
    cyc("R8 second only",       0, 4'b0011, 4'd3,  1, 4'b1111, 4'd15, '1);
    cyc("R10 empty mask",       1, 4'b0000, 4'd5,  1, 4'b0100, 4'd2, '1);
    cyc("R10 nothing valid",    0, 4'b1111, 4'd9,  0, 4'b0011, 4'd4, '1);
    cyc("R10 empty mask 2nd",   1, 4'b1111, 4'd15, 1, 4'b0000, 4'd3, '1);

    for (int n = 0; n < 400; n++) begin
      logic [SLOTS-1:0] bv;
      bv = SLOTS'($urandom) | SLOTS'($urandom);
      cyc("R9 random", 1'($urandom), 4'($urandom), 4'($urandom),
          1'($urandom), 4'($urandom), 4'($urandom), bv);
    end

    cyc("R10 flush", 0, 4'b0000, 4'd0, 0, 4'b0000, 4'd0, '0);
    cyc("R10 flush", 0, 4'b0000, 4'd0, 0, 4'b0000, 4'd0, '0);
    @(negedge clk); compare_head();
    @(negedge clk); compare_head();

    done = 1;
    summary();
    $finish;
  end

endmodule